// File: doc/BRIEF.md
# Head Seek and Recalibrate Step Controller

This block positions the read/write heads of up to four floppy drives. A seek moves a drive from its present cylinder to a requested one. A recalibrate steps a drive outward until the drive reports that it is on track 0. Each drive has its own stepping engine, so seeks on different drives can overlap. Each engine keeps that drive's present-cylinder register and produces a step pulse and a direction level. Pulses are spaced by an interval that a 4-bit step-rate code sets when the command starts.

When a command ends, the engine leaves a completion status byte behind. The drive's busy flag stays set until software collects that status with a sense request. The sense answer is the status byte followed by the present cylinder of the lowest-numbered drive that has a completion waiting. While any drive is busy, a block output tells the command sequencer that data-transfer commands must wait.

Top module: `head_step_ctrl`

## Requirements
- R1: After reset all step outputs, busy flags, `rw_block`, `int_req` and `sense_valid` are 0, and every present cylinder is 0.
- R2: Step pulses are spaced (16 - srt) x TICKS_PER_MS tick-enable pulses apart, doubled when HALF_CLOCK is 1. The srt code is taken at the start. The first pulse comes one full interval after the start.
- R3: A seek issues exactly |target - present| step pulses, each one clock wide, and updates the present cylinder by one per pulse. It then completes with status bits 7:6 = 00, bit 5 (seek end) = 1, bit 2 = head and bits 1:0 = drive.
- R4: `step_dir` is 1 (outward) for a recalibrate and for a seek whose target is below the present cylinder, and 0 otherwise. It holds steady while the drive steps.
- R5: A seek to the present cylinder, or a recalibrate started with track 0 already asserted, completes with no step pulse and normal status. The recalibrate also sets the cylinder to 0.
- R6: During a recalibrate, track 0 is sampled each time an interval expires. When it is high, the recalibrate ends with the present cylinder set to 0 and normal status.
- R7: A recalibrate that has issued RECAL_LIMIT (default 77) steps without seeing track 0 ends at the next expiry with status bits 7:6 = 01, bit 5 = 1 and bit 4 (equipment check) = 1. The present cylinder is left unchanged.
- R8: A command started while the drive's ready input is low completes at once with no step, status bits 7:6 = 01, bit 5 = 1 and bit 3 (not ready) = 1, and an unchanged cylinder.
- R9: A drive's busy flag rises when its start is accepted and falls only at the sense that reports it. A start for a busy drive is ignored.
- R10: `rw_block` is high exactly when any drive is busy, and `int_req` is high when any completion waits.
- R11: One clock after `sense_req`, `sense_valid` pulses with the status and cylinder of the lowest-numbered waiting drive, and that completion is cleared.
- R12: A sense with no waiting completion returns status 0x80 (code 2) and cylinder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start a command this cycle |
| start_recal | input | 1 | 1 = recalibrate, 0 = seek |
| start_drive | input | 2 | Drive number |
| start_head | input | 1 | Head reported in status bit 2 |
| start_cyl | input | CYL_W | Seek target cylinder |
| srt | input | 4 | Step-rate code |
| tick | input | 1 | Time-base enable |
| track0 | input | NUM_DRIVES | Track-0 sense per drive |
| ready | input | NUM_DRIVES | Drive ready per drive |
| sense_req | input | 1 | Collect one completion |
| step | output | NUM_DRIVES | Step pulse per drive |
| step_dir | output | NUM_DRIVES | 1 = outward per drive |
| drv_busy | output | NUM_DRIVES | Per-drive busy flag |
| rw_block | output | 1 | Data-transfer commands must wait |
| int_req | output | 1 | A completion is waiting |
| sense_valid | output | 1 | Sense answer valid |
| sense_st0 | output | 8 | Status byte |
| sense_pcn | output | CYL_W | Present cylinder |

## Verification
The bench targets the recalibrate that never sees track 0. A design with an off-by-one step cap would issue 76 or 78 pulses, or would report a normal status. It also lets track 0 rise after exactly three pulses: an engine that samples it at the wrong point would step once more or stop early. It completes two drives out of numeric order and then asks for their status twice. A wrong priority order or a stale clear would return the drives swapped or return one of them twice. Starts aimed at a busy drive, a drive that is not ready and a zero-distance seek each test that no spurious pulse appears and that the cylinder is left as it was.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

   typedef enum logic [1:0] {
      IC_NORMAL  = 2'b00,
      IC_ABORT   = 2'b01,
      IC_INVALID = 2'b10
   } int_code_e;

   // status byte layout: [7:6] code, [5] seek end, [4] equipment check,
   // [3] not ready, [2] head, [1:0] drive
   function automatic logic [7:0] pack_status(int_code_e code, logic seek_end,
                                              logic equip, logic not_rdy,
                                              logic head, logic [1:0] drv);
      pack_status = {code, seek_end, equip, not_rdy, head, drv};
   endfunction

   localparam logic [7:0] IDLE_STATUS = {IC_INVALID, 6'b0};

endpackage

// File: rtl/step_engine.sv
module step_engine
   import hsc_pkg::*;
#(
   parameter int CYL_W       = 8,
   parameter int RECAL_LIMIT = 77,
   parameter int SCALE       = 1,
   parameter int DRV_ID      = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_recal,
   input  logic             start_head,
   input  logic [CYL_W-1:0] start_cyl,
   input  logic [3:0]       srt,
   input  logic             tick,
   input  logic             track0,
   input  logic             ready,
   output logic             step,
   output logic             dir,
   output logic [CYL_W-1:0] pcn,
   output logic             done,
   output logic [7:0]       status
);

   localparam int TW = $clog2(16 * SCALE + 1);
   localparam int SW = $clog2(RECAL_LIMIT + 1);
   localparam logic [1:0]    DRV   = 2'(DRV_ID);
   localparam logic [SW-1:0] LIMIT = SW'(RECAL_LIMIT);

   logic             running;
   logic             is_recal;
   logic             head_q;
   logic [TW-1:0]    timer;
   logic [TW-1:0]    interval_q;
   logic [CYL_W-1:0] target;
   logic [SW-1:0]    steps;
   logic [TW-1:0]    ivl_new;
   logic [CYL_W-1:0] pcn_next;

   assign ivl_new  = TW'((16 - int'(srt)) * SCALE);
   assign pcn_next = dir ? pcn - 1'b1 : pcn + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running    <= 1'b0;
         is_recal   <= 1'b0;
         head_q     <= 1'b0;
         timer      <= '0;
         interval_q <= '0;
         target     <= '0;
         steps      <= '0;
         step       <= 1'b0;
         dir        <= 1'b0;
         pcn        <= '0;
         done       <= 1'b0;
         status     <= '0;
      end else begin
         step <= 1'b0;
         done <= 1'b0;
         if (start) begin
            head_q     <= start_head;
            is_recal   <= start_recal;
            interval_q <= ivl_new;
            target     <= start_cyl;
            steps      <= '0;
            if (!ready) begin
               done   <= 1'b1;
               status <= pack_status(IC_ABORT, 1'b1, 1'b0, 1'b1, start_head, DRV);
            end else if (start_recal && track0) begin
               done   <= 1'b1;
               pcn    <= '0;
               status <= pack_status(IC_NORMAL, 1'b1, 1'b0, 1'b0, start_head, DRV);
            end else if (!start_recal && start_cyl == pcn) begin
               done   <= 1'b1;
               status <= pack_status(IC_NORMAL, 1'b1, 1'b0, 1'b0, start_head, DRV);
            end else begin
               running <= 1'b1;
               timer   <= ivl_new;
               dir     <= start_recal | (start_cyl < pcn);
            end
         end else if (running && tick) begin
            if (timer != TW'(1)) begin
               timer <= timer - 1'b1;
            end else begin
               timer <= interval_q;
               if (is_recal) begin
                  if (track0) begin
                     running <= 1'b0;
                     done    <= 1'b1;
                     pcn     <= '0;
                     status  <= pack_status(IC_NORMAL, 1'b1, 1'b0, 1'b0, head_q, DRV);
                  end else if (steps == LIMIT) begin
                     running <= 1'b0;
                     done    <= 1'b1;
                     status  <= pack_status(IC_ABORT, 1'b1, 1'b1, 1'b0, head_q, DRV);
                  end else begin
                     step  <= 1'b1;
                     steps <= steps + 1'b1;
                  end
               end else begin
                  step <= 1'b1;
                  pcn  <= pcn_next;
                  if (pcn_next == target) begin
                     running <= 1'b0;
                     done    <= 1'b1;
                     status  <= pack_status(IC_NORMAL, 1'b1, 1'b0, 1'b0, head_q, DRV);
                  end
               end
            end
         end
      end
   end

   // R3: a pulse only follows a cycle in which the engine was stepping
   a_r3_step_needs_run : assert property (@(posedge clk) disable iff (!rst_n)
      step |-> $past(running));

   // R4: direction does not move mid-command
   a_r4_dir_held : assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running)) |-> $stable(dir));

   // R7: recalibrate never passes its step cap
   a_r7_step_cap : assert property (@(posedge clk) disable iff (!rst_n)
      (running && is_recal) |-> (steps <= LIMIT));

endmodule

// File: rtl/sense_arb.sv
module sense_arb
   import hsc_pkg::*;
#(
   parameter int NUM_DRIVES = 4,
   parameter int CYL_W      = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sense_req,
   input  logic [NUM_DRIVES-1:0] pending,
   input  logic [7:0]            st_in  [NUM_DRIVES],
   input  logic [CYL_W-1:0]      pcn_in [NUM_DRIVES],
   output logic [NUM_DRIVES-1:0] clr,
   output logic                  sense_valid,
   output logic [7:0]            sense_st0,
   output logic [CYL_W-1:0]      sense_pcn
);

   logic [7:0]       pick_st;
   logic [CYL_W-1:0] pick_pcn;

   always_comb begin
      clr      = '0;
      pick_st  = IDLE_STATUS;
      pick_pcn = '0;
      for (int d = NUM_DRIVES - 1; d >= 0; d--) begin
         if (pending[d]) begin
            clr      = '0;
            clr[d]   = sense_req;
            pick_st  = st_in[d];
            pick_pcn = pcn_in[d];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sense_valid <= 1'b0;
         sense_st0   <= '0;
         sense_pcn   <= '0;
      end else begin
         sense_valid <= sense_req;
         if (sense_req) begin
            sense_st0 <= pick_st;
            sense_pcn <= pick_pcn;
         end
      end
   end

   // R11: at most one completion is collected per request
   a_r11_one_clear : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr));

   // R11: an answer only follows a request
   a_r11_valid_after_req : assert property (@(posedge clk) disable iff (!rst_n)
      sense_valid |-> $past(sense_req));

endmodule

// File: rtl/head_step_ctrl.sv
module head_step_ctrl
   import hsc_pkg::*;
#(
   parameter int NUM_DRIVES   = 4,
   parameter int CYL_W        = 8,
   parameter int RECAL_LIMIT  = 77,
   parameter int TICKS_PER_MS = 1,
   parameter bit HALF_CLOCK   = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_valid,
   input  logic                  start_recal,
   input  logic [1:0]            start_drive,
   input  logic                  start_head,
   input  logic [CYL_W-1:0]      start_cyl,
   input  logic [3:0]            srt,
   input  logic                  tick,
   input  logic [NUM_DRIVES-1:0] track0,
   input  logic [NUM_DRIVES-1:0] ready,
   input  logic                  sense_req,
   output logic [NUM_DRIVES-1:0] step,
   output logic [NUM_DRIVES-1:0] step_dir,
   output logic [NUM_DRIVES-1:0] drv_busy,
   output logic                  rw_block,
   output logic                  int_req,
   output logic                  sense_valid,
   output logic [7:0]            sense_st0,
   output logic [CYL_W-1:0]      sense_pcn
);

   localparam int SCALE = TICKS_PER_MS * (HALF_CLOCK ? 2 : 1);

   if (NUM_DRIVES < 1 || NUM_DRIVES > 4) begin : g_bad_drives
      $error("NUM_DRIVES must lie in 1..4");
   end
   if (CYL_W < 2) begin : g_bad_cyl
      $error("CYL_W must be at least 2");
   end
   if (RECAL_LIMIT < 1) begin : g_bad_limit
      $error("RECAL_LIMIT must be at least 1");
   end
   if (TICKS_PER_MS < 1) begin : g_bad_ticks
      $error("TICKS_PER_MS must be at least 1");
   end

   logic [NUM_DRIVES-1:0] pending;
   logic [NUM_DRIVES-1:0] clr;
   logic [7:0]            st_arr  [NUM_DRIVES];
   logic [CYL_W-1:0]      pcn_arr [NUM_DRIVES];

   for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
      logic accept;
      logic eng_done;
      logic busy_r;
      logic pend_r;

      assign accept = start_valid && (start_drive == 2'(d)) && !busy_r;

      step_engine #(
         .CYL_W       (CYL_W),
         .RECAL_LIMIT (RECAL_LIMIT),
         .SCALE       (SCALE),
         .DRV_ID      (d)
      ) u_eng (
         .clk         (clk),
         .rst_n       (rst_n),
         .start       (accept),
         .start_recal (start_recal),
         .start_head  (start_head),
         .start_cyl   (start_cyl),
         .srt         (srt),
         .tick        (tick),
         .track0      (track0[d]),
         .ready       (ready[d]),
         .step        (step[d]),
         .dir         (step_dir[d]),
         .pcn         (pcn_arr[d]),
         .done        (eng_done),
         .status      (st_arr[d])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_r <= 1'b0;
            pend_r <= 1'b0;
         end else begin
            pend_r <= (pend_r | eng_done) & ~clr[d];
            if (accept)      busy_r <= 1'b1;
            else if (clr[d]) busy_r <= 1'b0;
         end
      end

      assign drv_busy[d] = busy_r;
      assign pending[d]  = pend_r;

      // R9: a waiting completion always belongs to a busy drive
      a_r9_pend_busy : assert property (@(posedge clk) disable iff (!rst_n)
         pend_r |-> busy_r);

      // R9: an idle drive never steps
      a_r9_idle_no_step : assert property (@(posedge clk) disable iff (!rst_n)
         !busy_r |-> !step[d]);
   end

   sense_arb #(
      .NUM_DRIVES (NUM_DRIVES),
      .CYL_W      (CYL_W)
   ) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .sense_req   (sense_req),
      .pending     (pending),
      .st_in       (st_arr),
      .pcn_in      (pcn_arr),
      .clr         (clr),
      .sense_valid (sense_valid),
      .sense_st0   (sense_st0),
      .sense_pcn   (sense_pcn)
   );

   assign rw_block = |drv_busy;
   assign int_req  = |pending;

   // R10: an interrupt request implies data transfers are blocked
   a_r10_int_blocks : assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> rw_block);

endmodule

// File: tb/head_step_ctrl_tb.sv
module head_step_ctrl_tb;

   localparam int ND = 4;
   localparam int CW = 8;
   localparam int LIM = 77;
   localparam int SCL = 2;   // TICKS_PER_MS = 1, HALF_CLOCK = 1

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_valid = 0, start_recal = 0, start_head = 0, sense_req = 0, tick = 0;
   logic [1:0] start_drive = 0;
   logic [CW-1:0] start_cyl = 0;
   logic [3:0] srt = 4'hF;
   logic [ND-1:0] track0 = '0, ready = '1;
   logic [ND-1:0] step, step_dir, drv_busy;
   logic rw_block, int_req, sense_valid;
   logic [7:0] sense_st0;
   logic [CW-1:0] sense_pcn;

   int checks = 0, errors = 0, cyc = 0;

   always #2 clk = ~clk;

   head_step_ctrl #(.NUM_DRIVES(ND), .CYL_W(CW), .RECAL_LIMIT(LIM),
                    .TICKS_PER_MS(1), .HALF_CLOCK(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_recal(start_recal),
      .start_drive(start_drive), .start_head(start_head), .start_cyl(start_cyl),
      .srt(srt), .tick(tick), .track0(track0), .ready(ready), .sense_req(sense_req),
      .step(step), .step_dir(step_dir), .drv_busy(drv_busy), .rw_block(rw_block),
      .int_req(int_req), .sense_valid(sense_valid), .sense_st0(sense_st0),
      .sense_pcn(sense_pcn));

   function automatic logic [7:0] st(int ic, int se, int ec, int nr, int hd, int d);
      return 8'(ic * 64 + se * 32 + ec * 16 + nr * 8 + hd * 4 + d);
   endfunction

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // time base: two ticks out of every three cycles
   always @(negedge clk) begin
      cyc <= cyc + 1;
      tick <= (cyc % 3) != 2;
   end

   // ---------------- behavioural reference model ----------------
   int  m_pcn[ND], m_tgt[ND], m_tmr[ND], m_ivl[ND], m_steps[ND];
   bit  m_run[ND], m_rec[ND], m_dir[ND], m_hd[ND], m_busy[ND], m_pend[ND], m_done[ND];
   int  m_st0[ND];
   bit  e_step[ND];
   bit  e_sv;
   int  e_st0, e_spcn;

   always @(posedge clk) begin : mdl
      int pick;
      bit ob[ND];
      if (!rst_n) begin
         for (int d = 0; d < ND; d++) begin
            m_pcn[d] = 0; m_tgt[d] = 0; m_tmr[d] = 0; m_ivl[d] = 0; m_steps[d] = 0;
            m_run[d] = 0; m_rec[d] = 0; m_dir[d] = 0; m_hd[d] = 0; m_busy[d] = 0;
            m_pend[d] = 0; m_done[d] = 0; m_st0[d] = 0; e_step[d] = 0;
         end
         e_sv = 0; e_st0 = 0; e_spcn = 0;
      end else begin
         for (int d = 0; d < ND; d++) ob[d] = m_busy[d];
         pick = -1;
         e_sv = sense_req;
         if (sense_req) begin
            e_st0 = 8'h80; e_spcn = 0;
            for (int d = 0; d < ND; d++)
               if (m_pend[d] && pick < 0) pick = d;
            if (pick >= 0) begin
               e_st0 = m_st0[pick]; e_spcn = m_pcn[pick];
               m_pend[pick] = 0; m_busy[pick] = 0;
            end
         end
         for (int d = 0; d < ND; d++) begin
            if (m_done[d]) m_pend[d] = 1;
            m_done[d] = 0;
            e_step[d] = 0;
            if (start_valid && start_drive == d && !ob[d]) begin
               m_busy[d] = 1; m_hd[d] = start_head; m_rec[d] = start_recal;
               m_ivl[d] = (16 - srt) * SCL; m_tgt[d] = start_cyl; m_steps[d] = 0;
               if (!ready[d]) begin
                  m_done[d] = 1; m_st0[d] = st(1, 1, 0, 1, start_head, d);
               end else if (start_recal && track0[d]) begin
                  m_done[d] = 1; m_pcn[d] = 0; m_st0[d] = st(0, 1, 0, 0, start_head, d);
               end else if (!start_recal && start_cyl == m_pcn[d]) begin
                  m_done[d] = 1; m_st0[d] = st(0, 1, 0, 0, start_head, d);
               end else begin
                  m_run[d] = 1; m_tmr[d] = m_ivl[d];
                  m_dir[d] = start_recal || (start_cyl < m_pcn[d]);
               end
            end else if (m_run[d] && tick) begin
               if (m_tmr[d] > 1) m_tmr[d]--;
               else begin
                  m_tmr[d] = m_ivl[d];
                  if (m_rec[d]) begin
                     if (track0[d]) begin
                        m_run[d] = 0; m_done[d] = 1; m_pcn[d] = 0;
                        m_st0[d] = st(0, 1, 0, 0, m_hd[d], d);
                     end else if (m_steps[d] == LIM) begin
                        m_run[d] = 0; m_done[d] = 1;
                        m_st0[d] = st(1, 1, 1, 0, m_hd[d], d);
                     end else begin
                        e_step[d] = 1; m_steps[d]++;
                     end
                  end else begin
                     e_step[d] = 1;
                     m_pcn[d] = m_dir[d] ? m_pcn[d] - 1 : m_pcn[d] + 1;
                     if (m_pcn[d] == m_tgt[d]) begin
                        m_run[d] = 0; m_done[d] = 1;
                        m_st0[d] = st(0, 1, 0, 0, m_hd[d], d);
                     end
                  end
               end
            end
         end
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         bit anyb, anyp;
         anyb = 0; anyp = 0;
         for (int d = 0; d < ND; d++) begin
            check("R2 R3", $sformatf("step[%0d]", d), step[d], e_step[d]);
            check("R4", $sformatf("step_dir[%0d]", d), step_dir[d], m_dir[d]);
            check("R9", $sformatf("drv_busy[%0d]", d), drv_busy[d], m_busy[d]);
            anyb |= m_busy[d]; anyp |= m_pend[d];
         end
         check("R10", "rw_block", rw_block, anyb);
         check("R10", "int_req", int_req, anyp);
         check("R11", "sense_valid", sense_valid, e_sv);
         if (sense_valid && e_sv) begin
            check("R11", "sense_st0", sense_st0, e_st0);
            check("R11", "sense_pcn", sense_pcn, e_spcn);
         end
      end
   end

   // step counters and tick counter since last start
   int step_cnt[ND];
   int tcount;
   always @(posedge clk) begin
      for (int d = 0; d < ND; d++) if (step[d]) step_cnt[d]++;
      if (start_valid) tcount <= 0;
      else if (tick) tcount <= tcount + 1;
   end

   task automatic clr_cnt();
      for (int d = 0; d < ND; d++) step_cnt[d] = 0;
   endtask

   task automatic cmd(bit rec, int drv, bit hd, int cyl, int rate);
      start_valid = 1; start_recal = rec; start_drive = 2'(drv);
      start_head = hd; start_cyl = CW'(cyl); srt = 4'(rate);
      @(negedge clk);
      start_valid = 0;
   endtask

   task automatic wait_int();
      for (int i = 0; i < 2000 && !int_req; i++) @(negedge clk);
   endtask

   task automatic sense(string req, int exp_st, int exp_pcn);
      sense_req = 1;
      @(negedge clk);
      sense_req = 0;
      check(req, "sense valid", sense_valid, 1);
      check(req, "sense status", sense_st0, exp_st);
      check(req, "sense cylinder", sense_pcn, exp_pcn);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "step", step, 0);
      check("R1", "busy", drv_busy, 0);
      check("R1", "rw_block", rw_block, 0);
      check("R1", "int_req", int_req, 0);
      check("R1", "sense_valid", sense_valid, 0);
      rst_n = 1;
      @(negedge clk);

      // R2 R3: seek drive 0 from 0 to 5, srt E -> 4 ticks per step
      clr_cnt();
      cmd(0, 0, 0, 5, 14);
      for (int i = 0; i < 100 && !step[0]; i++) @(negedge clk);
      check("R2", "ticks before first step", tcount, 4);
      wait_int();
      check("R10", "rw_block while pending", rw_block, 1);
      sense("R3", 8'h20, 5);
      check("R3", "step count up", step_cnt[0], 5);
      check("R9", "busy cleared by sense", drv_busy[0], 0);

      // R4: seek downward 5 -> 2
      clr_cnt();
      cmd(0, 0, 0, 2, 15);
      @(negedge clk);
      check("R4", "outward direction", step_dir[0], 1);
      wait_int();
      sense("R4", 8'h20, 2);
      check("R4", "step count down", step_cnt[0], 3);

      // R5: seek to present cylinder
      clr_cnt();
      cmd(0, 0, 0, 2, 15);
      wait_int();
      sense("R5", 8'h20, 2);
      check("R5", "no step on null seek", step_cnt[0], 0);

      // R12: sense with nothing waiting
      sense("R12", 8'h80, 0);

      // R6: drive 1 seek to 10, recalibrate with track 0 after 3 steps
      cmd(0, 1, 0, 10, 15);
      wait_int();
      sense("R3", 8'h21, 10);
      clr_cnt();
      cmd(1, 1, 1, 0, 15);
      for (int i = 0; i < 500 && step_cnt[1] < 3; i++) @(negedge clk);
      track0[1] = 1;
      wait_int();
      sense("R6", 8'h25, 0);
      check("R6", "recal steps", step_cnt[1], 3);

      // R5: recalibrate with track 0 already high
      clr_cnt();
      cmd(1, 1, 0, 0, 15);
      wait_int();
      sense("R5", 8'h21, 0);
      check("R5", "no step when on track 0", step_cnt[1], 0);

      // R7: drive 2 to 4, then recalibrate that never finds track 0
      cmd(0, 2, 0, 4, 15);
      wait_int();
      sense("R3", 8'h22, 4);
      clr_cnt();
      cmd(1, 2, 0, 0, 15);
      wait_int();
      sense("R7", 8'h72, 4);
      check("R7", "capped step count", step_cnt[2], LIM);

      // R8: drive 3 not ready
      clr_cnt();
      ready[3] = 0;
      cmd(0, 3, 1, 9, 15);
      wait_int();
      sense("R8", 8'h6F, 0);
      check("R8", "no step when not ready", step_cnt[3], 0);
      ready[3] = 1;

      // R11 R9: two drives finish, collected lowest first; busy start ignored
      cmd(0, 3, 0, 3, 15);
      cmd(0, 0, 0, 6, 15);
      cmd(0, 0, 0, 50, 15);
      repeat (200) @(negedge clk);
      check("R10", "int pending", int_req, 1);
      sense("R11", 8'h20, 6);
      sense("R11", 8'h23, 3);
      check("R10", "rw_block released", rw_block, 0);
      sense("R12", 8'h80, 0);

      repeat (5) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule